// File: doc/BRIEF.md
# Programmable Serial Frame Timing Engine

This block moves one data word at a time over a three-wire serial link. It sends a parallel transmit word out most significant bit first and gathers a receive word from the input line. All of its timing is counted in bit-clock periods: an optional delay before the data, the data length, two trailing dummy stretches, and a frame pulse whose start and width can be placed anywhere in the transfer, even partway through the word.

In master mode the block makes the bit clock and the frame itself. A `halfTick` strobe from an external divider marks each half period. In frame-slave mode the bit clock and the frame arrive on input pins, and the pins are treated as already synchronous to `clk`. A start pulse latches the configuration and the transmit word. A one-cycle `done` pulse presents the received word. Settings that break the timing rules are refused and raise a sticky error flag.

Top module: `serial_frame_engine`

## Requirements
- R1: After reset, `busy`, `done`, `sclkOut`, `frmOut`, `txd` and `cfgErr` are all 0.
- R2: In master mode the bit clock rests low. Each bit period is a low half followed by a high half, and each half ends on a cycle with `halfTick` high. A transfer lasts exactly T1+T2+T3+T4 periods (start delay + data length + tail A + tail B). While `busy` is low, `sclkOut` and `frmOut` stay 0.
- R3: The low T2 bits of `txWord` are sent MSB first in periods T1 to T1+T2-1. Bits of `txWord` above T2 are ignored. In every other period, and between transfers, `txd` holds the idle level latched at the most recently accepted start.
- R4: In master mode `frmOut` is high in exactly periods T5 to T5+T6-1 (frame-at to frame-at + frame-length - 1). This holds even when that window begins after the MSB.
- R5: `rxd` is sampled on the rising bit-clock edge of each data period, the edge opposite to the one that launches `txd`. The result is right-justified in `rxWord` with zeros above bit T2-1. It appears with a one-cycle `done` in the cycle after the final falling edge.
- R6: A start is refused, and `cfgErr` is set, when any of these holds: T6 = 0, T6 ≥ T2+T3+T4, T5+T6 < T1+1, or T2 is outside 4..DATA_W. `cfgErr` stays set until reset, and later valid starts still run.
- R7: In frame-slave mode a start is also refused, with `cfgErr` set, when T1 ≠ 0 or when T5 > T2.
- R8: In frame-slave mode a start only arms the block (`busy` high, `txd` at idle level). The transfer begins on a rising `frmIn`, and `txd` shows the MSB in the following cycle. Bits then follow `sclkIn` edges. `sclkOut` and `frmOut` stay 0.
- R9: `sclkIn` edges are ignored while no transfer is running. A start while `busy` is ignored, except in the case of R10.
- R10: A start that arrives in the same cycle as the final falling edge is accepted. That cycle both finishes the old transfer (with `done` and its `rxWord`) and begins the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgStartDly | input | 8 | T1, periods before the first data bit |
| cfgDataLen | input | 8 | T2, data bits per word (4..DATA_W) |
| cfgTailA | input | 8 | T3, first trailing dummy periods |
| cfgTailB | input | 8 | T4, second trailing dummy periods |
| cfgFrmAt | input | 8 | T5, period in which the frame rises |
| cfgFrmLen | input | 8 | T6, frame width in periods |
| cfgSlave | input | 1 | 1 = frame and bit clock are inputs |
| cfgIdleLvl | input | 1 | Level of `txd` outside data periods |
| start | input | 1 | Start pulse; latches configuration and `txWord` |
| txWord | input | DATA_W | Transmit word, right-justified |
| halfTick | input | 1 | Master half-period strobe |
| sclkIn | input | 1 | Bit clock in frame-slave mode |
| frmIn | input | 1 | Frame in frame-slave mode |
| rxd | input | 1 | Serial receive data |
| sclkOut | output | 1 | Generated bit clock (master) |
| frmOut | output | 1 | Generated frame (master) |
| txd | output | 1 | Serial transmit data |
| busy | output | 1 | Armed or transferring |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rxWord | output | DATA_W | Received word, zero-filled above T2 |
| cfgErr | output | 1 | Sticky configuration error |

## Verification
The two functions that can fall in one cycle are the end of a transfer and the acceptance of the next start. The bench provokes this with the fastest half-period strobe. It counts bit-clock rises until the last period is high, then raises `start` for the very edge on which the clock falls for the last time. It judges the result by seeing, in the next cycle, `done` carrying the old word's received data together with `busy` still high and `txd` already showing the new word's MSB. Later it checks the second word's received data.

// File: rtl/sft_pkg.sv
package sft_pkg;

  localparam int FIELD_W = 8;
  localparam int SUM_W   = FIELD_W + 2;

  typedef logic [FIELD_W-1:0] fld_t;
  typedef logic [SUM_W-1:0]   sum_t;

  typedef struct packed {
    fld_t startDly;
    fld_t dataLen;
    fld_t tailA;
    fld_t tailB;
    fld_t frmAt;
    fld_t frmLen;
    logic slave;
    logic idleLvl;
  } timing_cfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic shift;
    logic capture;
    logic finish;
    logic active;
    logic idleLvl;
  } dp_strobe_t;

  function automatic logic cfgValid(timing_cfg_t c, int unsigned maxLen);
    sum_t tail;
    sum_t frmEnd;
    logic ok;
    tail   = sum_t'(c.dataLen) + sum_t'(c.tailA) + sum_t'(c.tailB);
    frmEnd = sum_t'(c.frmAt) + sum_t'(c.frmLen);
    ok     = 1'b1;
    if (c.frmLen == '0) ok = 1'b0;
    if (sum_t'(c.frmLen) >= tail) ok = 1'b0;
    if (frmEnd < sum_t'(c.startDly) + sum_t'(1)) ok = 1'b0;
    if (c.dataLen < fld_t'(4)) ok = 1'b0;
    if (32'(c.dataLen) > maxLen) ok = 1'b0;
    if (c.slave && (c.startDly != '0)) ok = 1'b0;
    if (c.slave && (c.frmAt > c.dataLen)) ok = 1'b0;
    return ok;
  endfunction

endpackage

// File: rtl/sft_ctrl.sv
module sft_ctrl
  import sft_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  timing_cfg_t cfgIn,
  input  logic        start,
  input  logic        halfTick,
  input  logic        sclkIn,
  input  logic        frmIn,
  output dp_strobe_t  strb,
  output fld_t        loadLen,
  output logic        sclkOut,
  output logic        frmOut,
  output logic        busy,
  output logic        cfgErr
);

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_RUN} st_t;

  st_t         state;
  timing_cfg_t cfgR;
  sum_t        period;
  logic        sclkR, sclkPrev, frmPrev, errR;

  sum_t total, dataEnd, frmEnd;
  logic running, riseEv, fallEv, lastPer, finish, inData;
  logic canStart, cfgOk, startOk, frmRise;

  always_comb begin
    total   = sum_t'(cfgR.startDly) + sum_t'(cfgR.dataLen)
            + sum_t'(cfgR.tailA) + sum_t'(cfgR.tailB);
    dataEnd = sum_t'(cfgR.startDly) + sum_t'(cfgR.dataLen);
    frmEnd  = sum_t'(cfgR.frmAt) + sum_t'(cfgR.frmLen);
    running = (state == ST_RUN);
    if (cfgR.slave) begin
      riseEv = running && sclkIn && !sclkPrev;
      fallEv = running && !sclkIn && sclkPrev;
    end else begin
      riseEv = running && halfTick && !sclkR;
      fallEv = running && halfTick && sclkR;
    end
    lastPer  = (period == total - sum_t'(1));
    finish   = fallEv && lastPer;
    inData   = running && (period >= sum_t'(cfgR.startDly)) && (period < dataEnd);
    canStart = (state == ST_IDLE) || finish;
    cfgOk    = cfgValid(cfgIn, DATA_W);
    startOk  = start && canStart && cfgOk;
    frmRise  = (state == ST_ARMED) && frmIn && !frmPrev;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cfgR     <= '0;
      period   <= '0;
      sclkR    <= 1'b0;
      sclkPrev <= 1'b0;
      frmPrev  <= 1'b0;
      errR     <= 1'b0;
    end else begin
      sclkPrev <= sclkIn;
      frmPrev  <= frmIn;
      if (start && canStart && !cfgOk) errR <= 1'b1;
      if (startOk) begin
        cfgR   <= cfgIn;
        state  <= cfgIn.slave ? ST_ARMED : ST_RUN;
        period <= '0;
        sclkR  <= 1'b0;
      end else if (finish) begin
        state <= ST_IDLE;
        sclkR <= 1'b0;
      end else if (frmRise) begin
        state  <= ST_RUN;
        period <= '0;
      end else if (running) begin
        if (!cfgR.slave && halfTick) sclkR <= ~sclkR;
        if (fallEv) period <= period + sum_t'(1);
      end
    end
  end

  always_comb begin
    strb.load    = startOk;
    strb.shift   = fallEv && inData;
    strb.capture = riseEv && inData;
    strb.finish  = finish;
    strb.active  = inData;
    strb.idleLvl = cfgR.idleLvl;
  end

  assign loadLen = cfgIn.dataLen;
  assign sclkOut = sclkR;
  assign frmOut  = running && !cfgR.slave && (period >= sum_t'(cfgR.frmAt)) && (period < frmEnd);
  assign busy    = (state != ST_IDLE);
  assign cfgErr  = errR;

endmodule

// File: rtl/sft_datapath.sv
module sft_datapath
  import sft_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strb,
  input  fld_t              loadLen,
  input  logic [DATA_W-1:0] txWord,
  input  logic              rxd,
  output logic              txd,
  output logic              done,
  output logic [DATA_W-1:0] rxWord
);

  logic [DATA_W-1:0] txSh, rxSh, rxWordR;
  logic              doneR;
  int unsigned       alignAmt;

  assign alignAmt = DATA_W - 32'(loadLen);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSh    <= '0;
      rxSh    <= '0;
      rxWordR <= '0;
      doneR   <= 1'b0;
    end else begin
      doneR <= strb.finish;
      if (strb.finish) rxWordR <= rxSh;
      if (strb.load) begin
        txSh <= txWord << alignAmt;
        rxSh <= '0;
      end else begin
        if (strb.shift)   txSh <= {txSh[DATA_W-2:0], 1'b0};
        if (strb.capture) rxSh <= {rxSh[DATA_W-2:0], rxd};
      end
    end
  end

  assign txd    = strb.active ? txSh[DATA_W-1] : strb.idleLvl;
  assign done   = doneR;
  assign rxWord = rxWordR;

endmodule

// File: rtl/serial_frame_engine.sv
module serial_frame_engine
  import sft_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        cfgStartDly,
  input  logic [7:0]        cfgDataLen,
  input  logic [7:0]        cfgTailA,
  input  logic [7:0]        cfgTailB,
  input  logic [7:0]        cfgFrmAt,
  input  logic [7:0]        cfgFrmLen,
  input  logic              cfgSlave,
  input  logic              cfgIdleLvl,
  input  logic              start,
  input  logic [DATA_W-1:0] txWord,
  input  logic              halfTick,
  input  logic              sclkIn,
  input  logic              frmIn,
  input  logic              rxd,
  output logic              sclkOut,
  output logic              frmOut,
  output logic              txd,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rxWord,
  output logic              cfgErr
);

  timing_cfg_t cfgIn;
  dp_strobe_t  strb;
  fld_t        loadLen;

  always_comb begin
    cfgIn.startDly = fld_t'(cfgStartDly);
    cfgIn.dataLen  = fld_t'(cfgDataLen);
    cfgIn.tailA    = fld_t'(cfgTailA);
    cfgIn.tailB    = fld_t'(cfgTailB);
    cfgIn.frmAt    = fld_t'(cfgFrmAt);
    cfgIn.frmLen   = fld_t'(cfgFrmLen);
    cfgIn.slave    = cfgSlave;
    cfgIn.idleLvl  = cfgIdleLvl;
  end

  sft_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgIn    (cfgIn),
    .start    (start),
    .halfTick (halfTick),
    .sclkIn   (sclkIn),
    .frmIn    (frmIn),
    .strb     (strb),
    .loadLen  (loadLen),
    .sclkOut  (sclkOut),
    .frmOut   (frmOut),
    .busy     (busy),
    .cfgErr   (cfgErr)
  );

  sft_datapath #(.DATA_W(DATA_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .loadLen (loadLen),
    .txWord  (txWord),
    .rxd     (rxd),
    .txd     (txd),
    .done    (done),
    .rxWord  (rxWord)
  );

endmodule

// File: rtl/serial_frame_engine_chk.sv
module serial_frame_engine_chk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic sclkOut,
  input logic frmOut,
  input logic txd,
  input logic cfgErr,
  input logic shiftS,
  input logic captureS
);

  // R2: clock and frame stay low while nothing is running
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclkOut && !frmOut));

  // R2: launch and capture belong to opposite clock edges
  p_edge_exclusive_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(shiftS && captureS));

  // R3: line level does not move between transfers
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> $stable(txd));

  // R4: frame only inside a transfer
  p_frame_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    frmOut |-> busy);

  // R5: done is a single-cycle pulse that ends a transfer
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_after_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

  // R6: error flag is sticky
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);

endmodule

bind serial_frame_engine serial_frame_engine_chk chk (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (busy),
  .done     (done),
  .sclkOut  (sclkOut),
  .frmOut   (frmOut),
  .txd      (txd),
  .cfgErr   (cfgErr),
  .shiftS   (strb.shift),
  .captureS (strb.capture)
);

// File: tb/tb_serial_frame_engine.sv
module tb_serial_frame_engine;

  localparam int DATA_W = 32;

  typedef struct packed {
    logic [7:0]  t1, t2, t3, t4, t5, t6;
    logic        idle;
    logic [1:0]  tick;
    logic [31:0] tx;
    logic [31:0] rx;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{8'd0, 8'd8,  8'd1, 8'd1, 8'd0, 8'd2, 1'b0, 2'd1, 32'hDEAD_BEA5, 32'hFFFF_FF3C},
    '{8'd2, 8'd12, 8'd2, 8'd1, 8'd1, 8'd3, 1'b1, 2'd2, 32'h1234_5ABC, 32'hABCD_E123},
    '{8'd0, 8'd16, 8'd0, 8'd0, 8'd5, 8'd4, 1'b0, 2'd3, 32'h0000_C3A5, 32'h5A5A_0F0F},
    '{8'd1, 8'd32, 8'd0, 8'd2, 8'd1, 8'd1, 1'b1, 2'd1, 32'h8000_0001, 32'h7FFF_FFFE},
    '{8'd3, 8'd4,  8'd3, 8'd0, 8'd3, 8'd1, 1'b0, 2'd2, 32'h0000_00F9, 32'hFFFF_FFF6}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] cfgStartDly = '0, cfgDataLen = '0, cfgTailA = '0, cfgTailB = '0;
  logic [7:0] cfgFrmAt = '0, cfgFrmLen = '0;
  logic cfgSlave = 1'b0, cfgIdleLvl = 1'b0, start = 1'b0;
  logic [DATA_W-1:0] txWord = '0;
  logic halfTick = 1'b0, sclkIn = 1'b0, frmIn = 1'b0, rxd = 1'b0;
  logic sclkOut, frmOut, txd, busy, done, cfgErr;
  logic [DATA_W-1:0] rxWord;

  int total = 0;
  int bad = 0;
  int tickEvery = 1;
  int tickCnt = 0;
  logic sawDone = 1'b0;
  logic [31:0] gotRx = '0;

  always #4 clk = ~clk;

  serial_frame_engine #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN),
    .cfgStartDly(cfgStartDly), .cfgDataLen(cfgDataLen), .cfgTailA(cfgTailA),
    .cfgTailB(cfgTailB), .cfgFrmAt(cfgFrmAt), .cfgFrmLen(cfgFrmLen),
    .cfgSlave(cfgSlave), .cfgIdleLvl(cfgIdleLvl), .start(start), .txWord(txWord),
    .halfTick(halfTick), .sclkIn(sclkIn), .frmIn(frmIn), .rxd(rxd),
    .sclkOut(sclkOut), .frmOut(frmOut), .txd(txd), .busy(busy), .done(done),
    .rxWord(rxWord), .cfgErr(cfgErr)
  );

  task automatic step();
    halfTick = (tickCnt == tickEvery - 1);
    tickCnt  = halfTick ? 0 : tickCnt + 1;
    @(posedge clk);
    @(negedge clk);
    if (done) begin
      sawDone = 1'b1;
      gotRx   = rxWord;
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; start = 1'b0; sclkIn = 1'b0; frmIn = 1'b0; rxd = 1'b0;
    cfgSlave = 1'b0;
    repeat (3) step();
    rstN = 1'b1;
    step();
  endtask

  task automatic applyCfg(input logic [7:0] t1, t2, t3, t4, t5, t6,
                          input logic slave, input logic idle);
    cfgStartDly = t1; cfgDataLen = t2; cfgTailA = t3; cfgTailB = t4;
    cfgFrmAt = t5; cfgFrmLen = t6; cfgSlave = slave; cfgIdleLvl = idle;
  endtask

  function automatic logic expTx(vec_t v, int k);
    if (k >= int'(v.t1) && k < int'(v.t1) + int'(v.t2))
      return v.tx[int'(v.t2) - 1 - (k - int'(v.t1))];
    return v.idle;
  endfunction

  function automatic logic expFrm(vec_t v, int k);
    return (k >= int'(v.t5)) && (k < int'(v.t5) + int'(v.t6));
  endfunction

  function automatic logic rxBit(vec_t v, int k);
    if (k >= int'(v.t1) && k < int'(v.t1) + int'(v.t2))
      return v.rx[int'(v.t2) - 1 - (k - int'(v.t1))];
    return 1'b1;
  endfunction

  function automatic logic [31:0] rxExp(vec_t v);
    logic [63:0] m;
    m = (64'd1 << v.t2) - 64'd1;
    return v.rx & m[31:0];
  endfunction

  task automatic runMaster(input vec_t v);
    int rises = 0;
    int txErr = 0;
    int frmErr = 0;
    logic prevS = 1'b0;
    int periods = int'(v.t1) + int'(v.t2) + int'(v.t3) + int'(v.t4);
    applyCfg(v.t1, v.t2, v.t3, v.t4, v.t5, v.t6, 1'b0, v.idle);
    tickEvery = int'(v.tick); tickCnt = 0; sawDone = 1'b0;
    txWord = v.tx; rxd = rxBit(v, 0); start = 1'b1;
    step();
    start = 1'b0;
    for (int g = 0; g < 4000; g++) begin
      if (sclkOut && !prevS) begin
        if (txd !== expTx(v, rises)) begin
          txErr++;
          $display("  period %0d txd %b want %b", rises, txd, expTx(v, rises));
        end
        if (frmOut !== expFrm(v, rises)) begin
          frmErr++;
          $display("  period %0d frm %b want %b", rises, frmOut, expFrm(v, rises));
        end
        rises++;
      end else if (!sclkOut && prevS) begin
        rxd = rxBit(v, rises);
      end
      prevS = sclkOut;
      if (sawDone) break;
      step();
    end
    chk(rises == periods, "R2", "bit period count", rises, periods);
    chk(txErr == 0, "R3", "tx bit errors", txErr, 0);
    chk(frmErr == 0, "R4", "frame period errors", frmErr, 0);
    chk(sawDone && gotRx == rxExp(v), "R5", "received word", gotRx, rxExp(v));
    step();
    chk(!done && !busy && txd == v.idle && !sclkOut, "R3", "idle after transfer",
        {done, busy, txd, sclkOut}, {3'b000, v.idle, 1'b0});
  endtask

  task automatic errCase(input logic [7:0] t1, t2, t3, t4, t5, t6,
                         input logic slave, input string req);
    doReset();
    applyCfg(t1, t2, t3, t4, t5, t6, slave, 1'b0);
    txWord = 32'h55; start = 1'b1;
    step();
    start = 1'b0;
    step();
    chk(cfgErr && !busy, req, "refused configuration", {cfgErr, busy}, 2'b10);
  endtask

  initial begin
    #(8 * 180000);
    total++;
    bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    doReset();
    chk({busy, done, sclkOut, frmOut, txd, cfgErr} == 6'b0, "R1", "reset outputs",
        {busy, done, sclkOut, frmOut, txd, cfgErr}, 0);

    // table walk: R2..R5
    for (int i = 0; i < 5; i++) runMaster(VECS[i]);

    // R10 back-to-back: start on the final falling edge
    begin
      vec_t v;
      int rises;
      logic prevS;
      int periods;
      v = VECS[0];
      periods = int'(v.t1) + int'(v.t2) + int'(v.t3) + int'(v.t4);
      applyCfg(v.t1, v.t2, v.t3, v.t4, v.t5, v.t6, 1'b0, 1'b0);
      tickEvery = 1; tickCnt = 0; sawDone = 1'b0; rxd = 1'b0;
      rises = 0; prevS = 1'b0;
      txWord = v.tx; start = 1'b1;
      step();
      start = 1'b0;
      for (int g = 0; g < 200; g++) begin
        if (sclkOut && !prevS) rises++;
        prevS = sclkOut;
        if (rises == periods) break;
        step();
      end
      txWord = 32'h0000_00C3; start = 1'b1;
      step();
      start = 1'b0;
      chk(done && busy, "R10", "done with new transfer running", {done, busy}, 2'b11);
      chk(gotRx == 32'h0, "R10", "old word received", gotRx, 0);
      chk(txd == 1'b1, "R10", "new MSB on line", txd, 1);
      sawDone = 1'b0; rxd = 1'b1;
      for (int g = 0; g < 200; g++) begin
        if (sawDone) break;
        step();
      end
      chk(sawDone && gotRx == 32'h0000_00FF, "R10", "second word received", gotRx, 32'hFF);
    end

    // R6 and R7: refused settings
    errCase(8'd0, 8'd8, 8'd1, 8'd1, 8'd0, 8'd0, 1'b0, "R6");
    errCase(8'd0, 8'd8, 8'd1, 8'd1, 8'd0, 8'd10, 1'b0, "R6");
    errCase(8'd3, 8'd8, 8'd1, 8'd1, 8'd1, 8'd2, 1'b0, "R6");
    errCase(8'd0, 8'd3, 8'd1, 8'd1, 8'd0, 8'd2, 1'b0, "R6");
    errCase(8'd0, 8'd33, 8'd1, 8'd1, 8'd0, 8'd2, 1'b0, "R6");
    errCase(8'd1, 8'd8, 8'd1, 8'd1, 8'd0, 8'd2, 1'b1, "R7");
    errCase(8'd0, 8'd8, 8'd1, 8'd1, 8'd9, 8'd1, 1'b1, "R7");
    runMaster(VECS[4]);
    chk(cfgErr, "R6", "flag sticky across valid run", cfgErr, 1);

    // R8 and R9: frame-slave transfer
    doReset();
    begin
      logic [7:0] txv;
      logic [7:0] rxv;
      int txErr;
      logic drove;
      txv = 8'h96; rxv = 8'h5C; txErr = 0; drove = 1'b0;
      applyCfg(8'd0, 8'd8, 8'd1, 8'd0, 8'd0, 8'd1, 1'b1, 1'b0);
      txWord = 32'hFFFF_FF00 | 32'(txv); sawDone = 1'b0;
      start = 1'b1;
      step();
      start = 1'b0;
      for (int j = 0; j < 3; j++) begin
        sclkIn = 1'b1; step(); step();
        sclkIn = 1'b0; step(); step();
      end
      chk(busy && txd == 1'b0 && !sawDone, "R9", "clock ignored while armed",
          {busy, txd, sawDone}, 3'b100);
      frmIn = 1'b1;
      step();
      chk(txd == txv[7], "R8", "MSB after frame rises", txd, txv[7]);
      for (int k = 0; k < 9; k++) begin
        rxd = (k < 8) ? rxv[7 - k] : 1'b1;
        if (k == 3) begin
          txWord = 32'h0; start = 1'b1;
        end
        sclkIn = 1'b1; step();
        start = 1'b0;
        if (sclkOut || frmOut) drove = 1'b1;
        if (txd !== ((k < 8) ? txv[7 - k] : 1'b0)) txErr++;
        step();
        if (k == 1) frmIn = 1'b0;
        sclkIn = 1'b0; step(); step();
        if (sclkOut || frmOut) drove = 1'b1;
      end
      chk(txErr == 0, "R9", "slave bits unchanged by start while busy", txErr, 0);
      chk(!drove, "R8", "no clock or frame driven", drove, 0);
      chk(sawDone && gotRx == 32'(rxv), "R8", "slave received word", gotRx, 32'(rxv));
      for (int j = 0; j < 2; j++) begin
        sclkIn = 1'b1; step(); step();
        sclkIn = 1'b0; step(); step();
      end
      chk(!busy && txd == 1'b0 && !done, "R9", "clock ignored while idle",
          {busy, txd, done}, 3'b000);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule